// File: doc/BRIEF.md
# Misaligned Load Access Unit

This unit serves byte, halfword and word loads on behalf of a requester, in front of a memory that is addressed by word and returns one full data word for each read strobe. The requester presents a byte address and a size. A load that fits inside one memory word is served with one read. A load whose bytes run past the end of a word is served with two reads on back-to-back cycles: the first word is held in a register, the second is appended, and the wanted bytes are shifted down and merged into a zero-extended result.

A strict-mode input chooses how misalignment is handled. An access is misaligned when its first byte address is not a multiple of its size. In strict mode a misaligned halfword or word load issues no read. It returns a fault instead. Byte loads never count as misaligned. Only one load is in flight at a time, and the request side stays not-ready until the response has been produced.

Top module: `unaligned_load_unit`

## Requirements
- R1: While reset is high, `req_ready_o` is 1 and `mem_rd_o`, `rsp_valid_o` and `rsp_fault_o` are 0.
- R2: `req_size_i` encodes the size: 0 is a byte, 1 is a halfword, and 2 or 3 is a word. A halfword or word load that stays inside one word issues exactly one strobe, and that strobe carries word address `addr >> 2`. The response is visible in the cycle after the second clock edge that follows the acceptance edge. Its data is little-endian: the byte at the lowest address lands in bits 7:0, and the unused upper bits are 0.
- R3: A byte load at any offset issues exactly one strobe. It returns the addressed byte in bits 7:0 with zeros above, on the same timing as R2.
- R4: A load whose last byte lies in the next word issues two strobes on consecutive cycles, to word N and then to word N+1. The word address wraps at the top of the word space. The response comes one cycle later than under R2, with the bytes of both words merged in address order.
- R5: When not in strict mode, a halfword at byte offset 1 takes a single read. A halfword at byte offset 3 is split across two reads as in R4.
- R6: In strict mode, a misaligned halfword or word load issues no strobe. The unit raises `rsp_fault_o` together with `rsp_valid_o` in the cycle after the acceptance edge, and `rsp_data_o` is 0 in that cycle.
- R7: Strict mode does not change byte loads or aligned loads. These are served as in R2 and R3 and never fault.
- R8: `req_ready_o` is 0 from the acceptance edge until the response appears. A `req_valid_i` held high during that time is ignored and causes no extra strobe.
- R9: `rsp_valid_o` and `rsp_fault_o` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strict_i | input | 1 | 1 makes misaligned halfword/word loads fault |
| req_valid_i | input | 1 | Load request present |
| req_ready_o | output | 1 | Unit idle, request accepted on this edge |
| req_addr_i | input | ADDR_W | Byte address of the first byte |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2/3 word |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | ADDR_W-2 | Word address of the read |
| mem_rdata_i | input | DATA_W | Read word, valid one cycle after the strobe |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_data_o | output | DATA_W | Zero-extended load result |
| rsp_fault_o | output | 1 | Misalignment fault, paired with rsp_valid_o |

## Verification
The bench builds the unit with an 8-bit byte address and a 32-bit word. With those values the word address is only 6 bits wide, so a word load at byte 0xFE wraps from word 63 to word 0 and reaches the wrap case in R4. The narrow address space also lets the memory model compute every byte from its address, which makes the expected result of each offset and size easy to derive. A 32-bit word gives all four offsets, so every combination of offset and size, in both modes, is reachable from a short table.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD_A = 2'd1,
    ST_RD_B = 2'd2,
    ST_DATA = 2'd3
  } ldu_state_t;
endpackage

// File: rtl/ldu_classify.sv
module ldu_classify #(
  parameter int BYTES = 4,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  output logic             misaligned_o,
  output logic             crossing_o
);
  logic [OFF_W:0] nbytes;
  logic [OFF_W:0] off_ext;

  always_comb begin
    off_ext = {1'b0, off_i};
    if (size_i[1])      nbytes = (OFF_W+1)'(4);
    else if (size_i[0]) nbytes = (OFF_W+1)'(2);
    else                nbytes = (OFF_W+1)'(1);
    misaligned_o = (off_ext & (nbytes - 1'b1)) != '0;
    crossing_o   = (off_ext + nbytes) > (OFF_W+1)'(BYTES);
  end
endmodule

// File: rtl/ldu_merge.sv
module ldu_merge #(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        size_i,
  output logic [DATA_W-1:0] data_o
);
  logic [2*DATA_W-1:0] joined;
  logic [2*DATA_W-1:0] shifted;
  logic [DATA_W-1:0]   mask;

  always_comb begin
    joined  = {hi_i, lo_i};
    shifted = joined >> {off_i, 3'b000};
    if (size_i[1])      mask = {DATA_W{1'b1}};
    else if (size_i[0]) mask = DATA_W'(16'hFFFF);
    else                mask = DATA_W'(8'hFF);
    data_o = shifted[DATA_W-1:0] & mask;
  end
endmodule

// File: rtl/unaligned_load_unit.sv
module unaligned_load_unit
  import ldu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BYTES  = DATA_W / 8,
  localparam int OFF_W  = $clog2(BYTES),
  localparam int WORD_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strict_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  output logic              mem_rd_o,
  output logic [WORD_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              rsp_fault_o
);
  ldu_state_t        state_q;
  logic [WORD_W-1:0] word_q;
  logic [OFF_W-1:0]  off_q;
  logic [1:0]        size_q;
  logic              split_q;
  logic [DATA_W-1:0] hold_q;
  logic              mem_rd_q;
  logic [WORD_W-1:0] mem_addr_q;
  logic              rsp_valid_q;
  logic              rsp_fault_q;
  logic [DATA_W-1:0] rsp_data_q;

  logic [OFF_W-1:0]  in_off;
  logic [WORD_W-1:0] in_word;
  logic              in_mis;
  logic              in_cross;
  logic [DATA_W-1:0] merge_lo;
  logic [DATA_W-1:0] merged;

  assign in_off  = req_addr_i[OFF_W-1:0];
  assign in_word = req_addr_i[ADDR_W-1:OFF_W];

  ldu_classify #(.BYTES(BYTES)) u_classify (
    .off_i        (in_off),
    .size_i       (req_size_i),
    .misaligned_o (in_mis),
    .crossing_o   (in_cross)
  );

  // first word comes from the hold register only on a split load
  assign merge_lo = split_q ? hold_q : mem_rdata_i;

  ldu_merge #(.DATA_W(DATA_W)) u_merge (
    .lo_i   (merge_lo),
    .hi_i   (mem_rdata_i),
    .off_i  (off_q),
    .size_i (size_q),
    .data_o (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      word_q      <= '0;
      off_q       <= '0;
      size_q      <= '0;
      split_q     <= 1'b0;
      hold_q      <= '0;
      mem_rd_q    <= 1'b0;
      mem_addr_q  <= '0;
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      rsp_fault_q <= 1'b0;
      mem_rd_q    <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            word_q  <= in_word;
            off_q   <= in_off;
            size_q  <= req_size_i;
            split_q <= in_cross;
            if (strict_i && in_mis) begin
              rsp_valid_q <= 1'b1;
              rsp_fault_q <= 1'b1;
              rsp_data_q  <= '0;
            end else begin
              mem_rd_q   <= 1'b1;
              mem_addr_q <= in_word;
              state_q    <= ST_RD_A;
            end
          end
        end
        ST_RD_A: begin
          if (split_q) begin
            mem_rd_q   <= 1'b1;
            mem_addr_q <= word_q + 1'b1;
            state_q    <= ST_RD_B;
          end else begin
            state_q <= ST_DATA;
          end
        end
        ST_RD_B: begin
          hold_q  <= mem_rdata_i;
          state_q <= ST_DATA;
        end
        default: begin
          rsp_valid_q <= 1'b1;
          rsp_data_q  <= merged;
          state_q     <= ST_IDLE;
        end
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_rd_o    = mem_rd_q;
  assign mem_addr_o  = mem_addr_q;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_fault_o = rsp_fault_q;
  assign rsp_data_o  = rsp_data_q;
endmodule

// File: rtl/ldu_chk.sv
module ldu_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              mem_rd_o,
  input logic              rsp_valid_o,
  input logic              rsp_fault_o,
  input logic [DATA_W-1:0] rsp_data_o
);
  // R8
  busy_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_o |-> !req_ready_o);

  // R8
  strobe_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_rd_o) |-> $past(req_valid_i && req_ready_o));

  // R4
  strobe_burst_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_o && $past(mem_rd_o)) |=> !mem_rd_o);

  // R6
  fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_fault_o |-> (rsp_valid_o && rsp_data_o == '0));

  // R2
  rsp_timing_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid_o && !rsp_fault_o) |-> (!$past(mem_rd_o) && $past(mem_rd_o, 2)));
endmodule

bind unaligned_load_unit ldu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .mem_rd_o    (mem_rd_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_fault_o (rsp_fault_o),
  .rsp_data_o  (rsp_data_o)
);

// File: tb/unaligned_load_unit_tb.sv
module unaligned_load_unit_tb;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int WW = AW - 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          strict = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic          mem_rd;
  logic [WW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          rsp_fault;

  int n_cmp = 0;
  int n_err = 0;
  int scnt = 0;
  logic [WW-1:0] saddr [4];

  always #10 clk = ~clk;

  unaligned_load_unit #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .strict_i(strict),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_size_i(req_size),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_fault_o(rsp_fault)
  );

  function automatic logic [7:0] bval(input logic [AW-1:0] a);
    return 8'(a * 8'd29 + 8'd7);
  endfunction

  function automatic logic [DW-1:0] word_of(input logic [WW-1:0] n);
    logic [DW-1:0] w;
    for (int i = 0; i < 4; i++) w[8*i +: 8] = bval(AW'({n, 2'b00} + i));
    return w;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= word_of(mem_addr);
    if (!rst && mem_rd) begin
      if (scnt < 4) saddr[scnt] = mem_addr;
      scnt = scnt + 1;
    end
  end

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // {strict, size, addr}
  localparam int NV = 18;
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'h10}, {1'b0, 2'd0, 8'h13}, {1'b0, 2'd1, 8'h20},
    {1'b0, 2'd1, 8'h21}, {1'b0, 2'd1, 8'h23}, {1'b0, 2'd2, 8'h40},
    {1'b0, 2'd2, 8'h41}, {1'b0, 2'd2, 8'h42}, {1'b0, 2'd2, 8'h43},
    {1'b0, 2'd3, 8'h50}, {1'b0, 2'd2, 8'hFE}, {1'b1, 2'd0, 8'h37},
    {1'b1, 2'd1, 8'h22}, {1'b1, 2'd1, 8'h25}, {1'b1, 2'd2, 8'h44},
    {1'b1, 2'd2, 8'h46}, {1'b1, 2'd1, 8'h27}, {1'b1, 2'd3, 8'h4D}
  };

  task automatic do_load(input logic s, input logic [1:0] sz,
                         input logic [AW-1:0] a, input bit linger);
    int nb, reads, lat, k;
    bit mis, flt, split;
    logic [DW-1:0] exp_d;
    logic [DW-1:0] got_d;
    logic got_f;
    string tag;
    nb    = sz[1] ? 4 : (sz[0] ? 2 : 1);
    mis   = (int'(a) % nb) != 0;
    flt   = s && mis;
    split = (int'(a[1:0]) + nb) > 4;
    reads = flt ? 0 : (split ? 2 : 1);
    lat   = flt ? 1 : (split ? 4 : 3);
    exp_d = '0;
    if (!flt) for (int i = 0; i < nb; i++) exp_d[8*i +: 8] = bval(AW'(a + i));
    if (flt)                                   tag = "R6";
    else if (s && nb > 1)                      tag = "R7";
    else if (nb == 1)                          tag = "R3";
    else if (nb == 2 && a[0])                  tag = "R5";
    else if (split)                            tag = "R4";
    else                                       tag = "R2";

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    scnt = 0;
    strict = s; req_size = sz; req_addr = a; req_valid = 1'b1;
    @(posedge clk);
    k = 0; got_d = '0; got_f = 1'b0;
    for (int c = 1; c <= 8; c++) begin
      @(negedge clk);
      if (linger && c <= 2) begin
        // R8: request held while busy must be ignored
        check("R8", "ready while busy", 32'(req_ready), 32'd0);
        req_addr = 8'hC1; req_size = 2'd0;
      end else begin
        req_valid = 1'b0;
      end
      if (rsp_valid && k == 0) begin
        k = c; got_d = rsp_data; got_f = rsp_fault;
        break;
      end
    end
    req_valid = 1'b0;
    check(tag, "latency", 32'(k), 32'(lat));
    check(tag, "data", got_d, exp_d);
    check(tag, "fault", 32'(got_f), 32'(flt));
    @(negedge clk);
    // R9: single-cycle response pulse
    check("R9", "valid pulse", 32'(rsp_valid), 32'd0);
    check("R9", "fault pulse", 32'(rsp_fault), 32'd0);
    check(tag, "strobes", 32'(scnt), 32'(reads));
    if (reads > 0) check(tag, "addr first", 32'(saddr[0]), 32'(a[AW-1:2]));
    if (reads > 1) check(tag, "addr second", 32'(saddr[1]), 32'(WW'(a[AW-1:2] + 1)));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "ready", 32'(req_ready), 32'd1);
    check("R1", "strobe", 32'(mem_rd), 32'd0);
    check("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    check("R1", "fault", 32'(rsp_fault), 32'd0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++)
      do_load(VEC[v][10], VEC[v][9:8], VEC[v][7:0], 1'b0);

    // R8: split load with the request held high during the busy cycles
    do_load(1'b0, 2'd2, 8'h62, 1'b1);
    // R4: wrap of the halfword split at the top of the space
    do_load(1'b0, 2'd1, 8'hFF, 1'b0);
    // R7: aligned word in strict mode right after a fault
    do_load(1'b1, 2'd2, 8'h61, 1'b0);
    do_load(1'b1, 2'd2, 8'h64, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule